// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold and Drain Requests

This block sits between a register port and an I2C byte engine. It keeps one byte FIFO for the transmit direction and one for the receive direction. Software, or a DMA channel, fills the transmit FIFO one byte per access. The engine pops bytes from it as it shifts them out. In the receive direction the engine pushes each received byte and the host side reads it back one byte per access.

Each direction has a programmable threshold. The block raises a *ready* request when a full threshold-sized burst can be moved. When fewer bytes than the threshold are left in the transfer, it raises a *drain* request instead, which asks the host to move exactly the remaining bytes. A transfer byte count, loaded before the transfer begins, tells the block how many bytes remain. The block keeps one remaining-count per direction. The transmit count goes down on each accepted host write and the receive count goes down on each accepted host read.

A configuration register holds the thresholds, the DMA-request enables and the flush strobes. A status register reports both fill levels and the encoded FIFO depth.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After a synchronous active-low reset, both FIFOs are empty, both remaining counts are zero, the configuration reads as zero (threshold of 1 in both directions, DMA disabled) and every request output is low.
- R2: Bytes accepted from the host write port leave on the engine transmit side in the same order. `eng_tx_valid` is high while the transmit FIFO holds data. Status bits 5:0 give the transmit fill level.
- R3: Bytes pushed by the engine come out on `host_rdata` in the same order, and a host read removes the head byte. `eng_rx_space` is high while the receive FIFO is not full. Status bits 13:8 give the receive fill level.
- R4: The configuration register reads back with this layout: bit 15 is the receive DMA enable, bits 13:8 the receive threshold minus one, bit 7 the transmit DMA enable and bits 5:0 the transmit threshold minus one. Bits 14 and 6 always read as zero.
- R5: A configuration write with bit 14 set empties the receive FIFO at that clock edge, and one with bit 6 set empties the transmit FIFO at that edge. A push or pop in the same cycle is dropped. The other FIFO is unaffected, and the rest of the written fields are stored.
- R6: Status bits 15:14 hold the depth code `DEPTH_CODE`, where depth = 8 << code. Status bits 7:6 read as zero.
- R7: A transfer-count write loads both remaining counts. A nonzero transmit count drops by one per accepted host write, and a nonzero receive count drops by one per accepted host read. A load wins over a decrement in the same cycle.
- R8: `tx_ready_req` is high when the transmit remaining count is at least the threshold and the free space is at least the threshold.
- R9: `tx_drain_req` is high when the transmit remaining count is nonzero and below the threshold, and the free space covers that count. It is never high together with `tx_ready_req`.
- R10: `rx_ready_req` is high when the receive fill level is at least the threshold and the receive remaining count is at least the threshold.
- R11: `rx_drain_req` is high when the receive remaining count is nonzero and below the threshold, and the fill level covers that count. It is never high together with `rx_ready_req`.
- R12: A host write while the transmit FIFO is full, or a host read while the receive FIFO is empty, is ignored. Contents, level and remaining count stay unchanged. An engine push into a full receive FIFO is also ignored.
- R13: `tx_dma_req` equals the transmit DMA enable ANDed with (ready or drain) for transmit. `rx_dma_req` is formed the same way for receive.
- R14: A programmed threshold (field + 1) larger than the FIFO depth acts as the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| stat_rdata | output | 16 | Status: depth code and fill levels |
| cnt_wr_en | input | 1 | Transfer byte count load strobe |
| cnt_wdata | input | CNT_W | Transfer byte count |
| host_wr_en | input | 1 | Host byte write into the transmit FIFO |
| host_wdata | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host byte read from the receive FIFO |
| host_rdata | output | 8 | Receive FIFO head byte |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit FIFO head byte |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_space | output | 1 | Receive FIFO not full |
| tx_ready_req | output | 1 | Transmit threshold burst can be written |
| tx_drain_req | output | 1 | Transmit end-of-transfer drain |
| rx_ready_req | output | 1 | Receive threshold burst can be read |
| rx_drain_req | output | 1 | Receive end-of-transfer drain |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with `DEPTH_CODE` = 0, which gives an 8-entry FIFO in each direction, and an 8-bit count. With so few entries, a handful of bytes fills either FIFO. This exposes the ignored write on a full FIFO, the ignored read on an empty one, and the point where a ready request turns into a drain request as the count falls below the threshold. A threshold field of 20 is larger than this depth, so the clamp to the depth also comes within reach. A long stretch of mixed random traffic, counts and configuration writes is then checked against a behavioural queue model on every clock.

// File: rtl/i2cfp_pkg.sv
// Package: shared field positions and configuration type of the FIFO pair.
// Assumes a 16-bit configuration/status word and 6-bit threshold fields.
package i2cfp_pkg;

    localparam int THR_W = 6;

    // Bit positions that software decodes in the configuration word.
    localparam int CFG_RX_DMA   = 15;
    localparam int CFG_RX_FLUSH = 14;
    localparam int CFG_RX_THR   = 8;
    localparam int CFG_TX_DMA   = 7;
    localparam int CFG_TX_FLUSH = 6;
    localparam int CFG_TX_THR   = 0;

    typedef struct packed {
        logic             rx_dma;
        logic [THR_W-1:0] rx_thr_m1;
        logic             tx_dma;
        logic [THR_W-1:0] tx_thr_m1;
    } fifo_cfg_t;

endpackage

// File: rtl/i2cfp_fifo.sv
// Module: single-clock byte FIFO with a synchronous flush.
// The head byte is shown without a read strobe (show-ahead).
// A push into a full FIFO and a pop from an empty FIFO are ignored.
// A flush wins over both push and pop in the same cycle.
// Assumes DEPTH is a power of two.
module i2cfp_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] count;
    logic          push_ok;
    logic          pop_ok;

    // Flags and accepted-operation qualifiers.
    always_comb begin
        full      = (count == LW'(DEPTH));
        empty     = (count == '0);
        push_ok   = push & ~full & ~flush;
        pop_ok    = pop & ~empty & ~flush;
        head_data = mem[rd_ptr];
        level     = count;
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + LW'(push_ok) - LW'(pop_ok);
        end
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    assert_full_push_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count) && wr_ptr == $past(wr_ptr)));

    assert_empty_pop_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (count == '0 && rd_ptr == $past(rd_ptr)));

endmodule

// File: rtl/i2cfp_req.sv
// Module: ready/drain request decision for one direction.
// "avail" is the free space (transmit) or the fill level (receive).
// The threshold is field + 1, clamped to DEPTH.
// The drain request replaces the ready request once the remaining count is
// nonzero and below the threshold.
// Assumes CNT_W is at least 7 bits.
module i2cfp_req #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH) + 1,
    parameter int CNT_W = 16,
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_m1,
    input  logic [CNT_W-1:0] left,
    input  logic [LW-1:0]    avail,
    output logic             ready,
    output logic             drain
);

    logic [CNT_W-1:0] thr_raw;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] avail_w;

    // Effective threshold and the two request decisions.
    always_comb begin
        thr_raw = CNT_W'(thr_m1) + CNT_W'(1);
        thr     = (thr_raw > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : thr_raw;
        avail_w = CNT_W'(avail);
        ready   = (left >= thr) && (avail_w >= thr);
        drain   = (left != '0) && (left < thr) && (avail_w >= left);
    end

    assert_ready_drain_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && drain));

    assert_drain_has_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        drain |-> (avail != '0));

endmodule

// File: rtl/i2c_fifo_pair.sv
// Module: transmit/receive byte FIFO pair for an I2C byte engine.
// It holds the configuration register, the remaining-count tracking per
// direction and the request outputs, and assembles the status word.
// Assumes DEPTH_CODE is 0..2, so that a fill level fits a 6-bit status field.
module i2c_fifo_pair
    import i2cfp_pkg::*;
#(
    parameter int DEPTH_CODE = 1,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    output logic [15:0]      stat_rdata,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             host_wr_en,
    input  logic [7:0]       host_wdata,
    input  logic             host_rd_en,
    output logic [7:0]       host_rdata,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_data,
    output logic             eng_tx_valid,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_data,
    output logic             eng_rx_space,
    output logic             tx_ready_req,
    output logic             tx_drain_req,
    output logic             rx_ready_req,
    output logic             rx_drain_req,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);

    localparam int DEPTH = 8 << DEPTH_CODE;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = AW + 1;

    fifo_cfg_t        cfg;
    logic             tx_flush, rx_flush;
    logic [LW-1:0]    tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_wr_acc, rx_rd_acc;
    logic [CNT_W-1:0] tx_left, rx_left;
    logic [LW-1:0]    tx_free;

    // Flush strobes and accepted host accesses.
    always_comb begin
        tx_flush  = cfg_wr_en & cfg_wdata[CFG_TX_FLUSH];
        rx_flush  = cfg_wr_en & cfg_wdata[CFG_RX_FLUSH];
        tx_wr_acc = host_wr_en & ~tx_full & ~tx_flush;
        rx_rd_acc = host_rd_en & ~rx_empty & ~rx_flush;
        tx_free   = LW'(DEPTH) - tx_level;
    end

    // Configuration register; the flush bits are strobes and are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr_en) begin
            cfg.rx_dma    <= cfg_wdata[CFG_RX_DMA];
            cfg.rx_thr_m1 <= cfg_wdata[CFG_RX_THR +: THR_W];
            cfg.tx_dma    <= cfg_wdata[CFG_TX_DMA];
            cfg.tx_thr_m1 <= cfg_wdata[CFG_TX_THR +: THR_W];
        end
    end

    // Remaining-byte counters: a load wins over a decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_left <= '0;
            rx_left <= '0;
        end else if (cnt_wr_en) begin
            tx_left <= cnt_wdata;
            rx_left <= cnt_wdata;
        end else begin
            if (tx_wr_acc && tx_left != '0) tx_left <= tx_left - CNT_W'(1);
            if (rx_rd_acc && rx_left != '0) rx_left <= rx_left - CNT_W'(1);
        end
    end

    i2cfp_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (host_wr_en),
        .push_data (host_wdata),
        .pop       (eng_tx_pop),
        .head_data (eng_tx_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    i2cfp_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (host_rd_en),
        .head_data (host_rdata),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    i2cfp_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_tx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .thr_m1 (cfg.tx_thr_m1),
        .left   (tx_left),
        .avail  (tx_free),
        .ready  (tx_ready_req),
        .drain  (tx_drain_req)
    );

    i2cfp_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W)) u_rx_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .thr_m1 (cfg.rx_thr_m1),
        .left   (rx_left),
        .avail  (rx_level),
        .ready  (rx_ready_req),
        .drain  (rx_drain_req)
    );

    // Edge handshakes, DMA requests and register read-back.
    always_comb begin
        eng_tx_valid = ~tx_empty;
        eng_rx_space = ~rx_full;
        tx_dma_req   = cfg.tx_dma & (tx_ready_req | tx_drain_req);
        rx_dma_req   = cfg.rx_dma & (rx_ready_req | rx_drain_req);
        cfg_rdata    = {cfg.rx_dma, 1'b0, cfg.rx_thr_m1, cfg.tx_dma, 1'b0, cfg.tx_thr_m1};
        stat_rdata   = {2'(DEPTH_CODE), 6'(rx_level), 2'b00, 6'(tx_level)};
    end

    assert_count_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (tx_left == $past(cnt_wdata) && rx_left == $past(cnt_wdata)));

    assert_tx_left_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !tx_full && !tx_flush && !cnt_wr_en && tx_left != '0)
        |=> (tx_left == $past(tx_left) - CNT_W'(1)));

    assert_rx_read_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && rx_empty && !cnt_wr_en) |=> $stable(rx_left));

endmodule

// File: tb/i2c_fifo_pair_bench.sv
`timescale 1ns/1ps
module i2c_fifo_pair_bench;

    localparam int DC    = 0;
    localparam int CW    = 8;
    localparam int DEPTH = 8 << DC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata, stat_rdata;
    logic          cnt_wr_en = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          host_wr_en = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic          host_rd_en = 1'b0;
    logic [7:0]    host_rdata;
    logic          eng_tx_pop = 1'b0;
    logic [7:0]    eng_tx_data;
    logic          eng_tx_valid;
    logic          eng_rx_push = 1'b0;
    logic [7:0]    eng_rx_data = '0;
    logic          eng_rx_space;
    logic          tx_ready_req, tx_drain_req, rx_ready_req, rx_drain_req;
    logic          tx_dma_req, rx_dma_req;

    always #2 clk = ~clk;

    i2c_fifo_pair #(.DEPTH_CODE(DC), .CNT_W(CW)) u_i2c_fifo_pair (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .stat_rdata(stat_rdata),
        .cnt_wr_en(cnt_wr_en), .cnt_wdata(cnt_wdata),
        .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rd_en(host_rd_en), .host_rdata(host_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_space(eng_rx_space),
        .tx_ready_req(tx_ready_req), .tx_drain_req(tx_drain_req),
        .rx_ready_req(rx_ready_req), .rx_drain_req(rx_drain_req),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    // Behavioural reference state.
    byte unsigned txq[$];
    byte unsigned rxq[$];
    int  m_tx_left = 0, m_rx_left = 0;
    int  m_tx_m1 = 0, m_rx_m1 = 0;
    bit  m_tx_dma = 0, m_rx_dma = 0;
    int  checks = 0, fails = 0;
    bit  finished = 0;

    task automatic chk(string what, string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic void reqs(int left, int avail, int m1, output bit rdy, output bit drn);
        int t;
        t = m1 + 1;
        if (t > DEPTH) t = DEPTH;
        rdy = (left >= t) && (avail >= t);
        drn = (left != 0) && (left < t) && (avail >= left);
    endfunction

    task automatic compare_all(string tag);
        bit tr, td, rr, rd;
        reqs(m_tx_left, DEPTH - txq.size(), m_tx_m1, tr, td);
        reqs(m_rx_left, rxq.size(), m_rx_m1, rr, rd);
        chk("cfg_rdata", tag, cfg_rdata,
            (int'(m_rx_dma) << 15) | (m_rx_m1 << 8) | (int'(m_tx_dma) << 7) | m_tx_m1);
        chk("stat_rdata", tag, stat_rdata, (DC << 14) | (rxq.size() << 8) | txq.size());
        chk("tx_ready_req", tag, tx_ready_req, tr);
        chk("tx_drain_req", tag, tx_drain_req, td);
        chk("rx_ready_req", tag, rx_ready_req, rr);
        chk("rx_drain_req", tag, rx_drain_req, rd);
        chk("tx_dma_req", tag, tx_dma_req, m_tx_dma & (tr | td));
        chk("rx_dma_req", tag, rx_dma_req, m_rx_dma & (rr | rd));
        chk("eng_tx_valid", tag, eng_tx_valid, txq.size() != 0);
        chk("eng_rx_space", tag, eng_rx_space, rxq.size() != DEPTH);
        if (txq.size() != 0) chk("eng_tx_data", tag, eng_tx_data, txq[0]);
        if (rxq.size() != 0) chk("host_rdata", tag, host_rdata, rxq[0]);
    endtask

    // One clock: model update from the inputs driven before this edge, then compare.
    task automatic tick(string tag);
        bit txf, rxf, tpush, tpop, rpush, rpop;
        @(posedge clk);
        txf   = cfg_wr_en && cfg_wdata[6];
        rxf   = cfg_wr_en && cfg_wdata[14];
        tpush = host_wr_en && txq.size() != DEPTH && !txf;
        tpop  = eng_tx_pop && txq.size() != 0 && !txf;
        rpush = eng_rx_push && rxq.size() != DEPTH && !rxf;
        rpop  = host_rd_en && rxq.size() != 0 && !rxf;
        if (txf) txq.delete();
        else begin
            if (tpop) void'(txq.pop_front());
            if (tpush) txq.push_back(host_wdata);
        end
        if (rxf) rxq.delete();
        else begin
            if (rpop) void'(rxq.pop_front());
            if (rpush) rxq.push_back(eng_rx_data);
        end
        if (cnt_wr_en) begin
            m_tx_left = cnt_wdata;
            m_rx_left = cnt_wdata;
        end else begin
            if (tpush && m_tx_left != 0) m_tx_left--;
            if (rpop && m_rx_left != 0) m_rx_left--;
        end
        if (cfg_wr_en) begin
            m_rx_dma = cfg_wdata[15];
            m_rx_m1  = cfg_wdata[13:8];
            m_tx_dma = cfg_wdata[7];
            m_tx_m1  = cfg_wdata[5:0];
        end
        @(negedge clk);
        cfg_wr_en = 0; cnt_wr_en = 0; host_wr_en = 0; host_rd_en = 0;
        eng_tx_pop = 0; eng_rx_push = 0;
        compare_all(tag);
    endtask

    task automatic cfg_write(logic [15:0] d, string tag);
        cfg_wr_en = 1; cfg_wdata = d; tick(tag);
    endtask

    task automatic cnt_load(int n, string tag);
        cnt_wr_en = 1; cnt_wdata = CW'(n); tick(tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all("R1");

        cfg_write(16'h8383, "R4");                 // thresholds 4, DMA on
        cfg_write(16'h8383, "R6");
        cnt_load(10, "R7");
        for (int i = 0; i < 9; i++) begin          // ninth write hits a full FIFO
            host_wr_en = 1; host_wdata = 8'h10 + 8'(i);
            tick(i == 8 ? "R12" : "R8");
        end
        for (int i = 0; i < 8; i++) begin          // left = 2 -> drain once room exists
            eng_tx_pop = 1; tick("R9");
        end
        for (int i = 0; i < 2; i++) begin
            host_wr_en = 1; host_wdata = 8'hA0 + 8'(i); tick("R9");
        end
        for (int i = 0; i < 2; i++) begin
            eng_tx_pop = 1; tick("R2");
        end

        cnt_load(6, "R7");
        for (int i = 0; i < 9; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'h50 + 8'(i);
            tick(i == 8 ? "R12" : "R10");
        end
        for (int i = 0; i < 6; i++) begin          // left drops below 4 -> drain
            host_rd_en = 1; tick(i < 3 ? "R3" : "R11");
        end
        host_wr_en = 1; host_wdata = 8'h77; tick("R13");
        cfg_write(16'hC383, "R5");                 // flush receive only
        host_rd_en = 1; tick("R12");               // read from empty
        eng_tx_pop = 1; tick("R2");

        cfg_write(16'h1414, "R14");                // threshold 21 -> 8, DMA off
        cnt_load(12, "R14");
        for (int i = 0; i < 5; i++) begin
            host_wr_en = 1; host_wdata = 8'hC0 + 8'(i); tick("R14");
        end
        for (int i = 0; i < 5; i++) begin
            eng_tx_pop = 1; tick("R14");
        end
        eng_rx_push = 1; eng_rx_data = 8'h33; tick("R13");
        host_wr_en = 1; host_wdata = 8'hEE; tick("R13");
        host_wr_en = 1; host_wdata = 8'hEF; cfg_wr_en = 1; cfg_wdata = 16'h1454;
        tick("R5");                                // transmit flush drops the write
        cnt_wr_en = 1; cnt_wdata = 8'd3; host_wr_en = 1; host_wdata = 8'h01;
        tick("R7");                                // load wins over decrement

        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(15) == 0) begin
                cfg_wr_en = 1;
                cfg_wdata = 16'($urandom) & 16'hFFFF;
                if ($urandom_range(3) != 0) cfg_wdata[14] = 1'b0;
                if ($urandom_range(3) != 0) cfg_wdata[6] = 1'b0;
                cfg_wdata[13:8] = 6'($urandom_range(9));
                cfg_wdata[5:0]  = 6'($urandom_range(9));
            end
            if ($urandom_range(19) == 0) begin
                cnt_wr_en = 1; cnt_wdata = CW'($urandom_range(20));
            end
            host_wr_en  = ($urandom_range(1) == 1);
            host_wdata  = 8'($urandom);
            host_rd_en  = ($urandom_range(2) == 0);
            eng_tx_pop  = ($urandom_range(2) == 0);
            eng_rx_push = ($urandom_range(1) == 1);
            eng_rx_data = 8'($urandom);
            tick("R8/R10");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule